// File: doc/BRIEF.md
# Highway and Farm-Road Intersection Light Controller

This block sequences the lamps of a crossing where a busy highway meets a lightly used farm road. The highway normally shows green. A car sensor on the farm road asks for service. The block grants it only after the highway has had a guaranteed minimum green, and then only after a yellow phase. The farm road keeps green while a car is still sensed, up to a cap. A second yellow phase then returns the right of way to the highway.

An internal interval timer sets all phase lengths. It is restarted on every phase change and reports a short expiry and a long expiry. The yellow phases use the short interval; the green phases use the long one. Both durations are parameters: `SHORT_CYC` and `LONG_CYC`, with 1 <= `SHORT_CYC` < `LONG_CYC`. The sensor input is asynchronous, so it passes through a two-flop synchroniser before the controller uses it. The active-low reset asserts asynchronously and is released through the same kind of synchroniser.

Top module: `xing_light_ctrl`

## Requirements
- R1: For each road, exactly one of its three lamps (green, yellow, red) is lit in every cycle. At least one road is always red, so the two roads never show green or yellow together.
- R2: While `rst_ni` is low, the highway shows green and the farm road shows red, from the moment reset is asserted. After release, the internal reset clears two edges later. With a car waiting from reset, the first highway green therefore lasts `LONG_CYC`+3 cycles.
- R3: Highway green is held until the synchronised sensor reports a car and the long interval has expired. With a car waiting, a highway green entered from farm yellow lasts exactly `LONG_CYC`+1 cycles. With no car, it lasts indefinitely.
- R4: Highway yellow lasts `SHORT_CYC`+1 cycles, after which farm green follows.
- R5: Farm green ends as soon as the synchronised sensor shows no car. If `car_i` falls two cycles into farm green, that green lasts 5 cycles in total.
- R6: With a car present throughout, farm green is capped at `LONG_CYC`+1 cycles and then moves to farm yellow.
- R7: Farm yellow lasts `SHORT_CYC`+1 cycles, after which highway green follows.
- R8: The sensor is seen through two flip-flops. Suppose `car_i` rises while the highway is green and its long interval has already expired. Highway yellow then appears after the third rising clock edge.
- R9: The timer restarts on every phase change. Its expiry flags are low right after a restart, stay high once raised until the next restart, and the long flag never shows without the short flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| car_i | input | 1 | Farm-road car sensor, asynchronous |
| hwy_grn_o | output | 1 | Highway green lamp |
| hwy_yel_o | output | 1 | Highway yellow lamp |
| hwy_red_o | output | 1 | Highway red lamp |
| farm_grn_o | output | 1 | Farm-road green lamp |
| farm_yel_o | output | 1 | Farm-road yellow lamp |
| farm_red_o | output | 1 | Farm-road red lamp |

## Verification
The controller assertions assume that the sensor, once past the synchroniser, holds a level for whole cycles. They also assume that the timer parameters keep the short interval strictly below the long one. The stimulus keeps within this in two ways. It changes `car_i` only on falling clock edges, and it uses the default intervals of 4 and 12 cycles. The timer assertions further assume that a restart arrives only from a phase change. In every scenario the stimulus therefore reaches the timer only through the sensor and reset, never directly.

// File: rtl/xing_pkg.sv
package xing_pkg;

  // Phase codes: the low bit selects the road that has the right of way
  // (0 highway, 1 farm), the high bit marks the yellow phase.
  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'b00,
    PH_HWY_WARN  = 2'b10,
    PH_FARM_GO   = 2'b01,
    PH_FARM_WARN = 2'b11
  } phase_e;

  typedef struct packed {
    logic go;
    logic warn;
    logic stop;
  } lamp_t;

endpackage

// File: rtl/xing_sync.sv
module xing_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/xing_timer.sv
module xing_timer #(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);

  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Count up from the restart and saturate at the long limit.
  always_comb begin
    cnt_en = restart || (cnt_q != LONG_L);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign short_done = (cnt_q >= SHORT_L);
  assign long_done  = (cnt_q == LONG_L);

  // R9: a restart clears both expiry flags
  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !short_done && !long_done);

  // R9: flags stay raised until the next restart
  assert_short_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (short_done && !restart) |=> short_done);

  assert_long_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (long_done && !restart) |=> long_done);

  // R9: the long expiry implies the short expiry
  assert_long_implies_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    long_done |-> short_done);

endmodule

// File: rtl/xing_fsm.sv
module xing_fsm
  import xing_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  car,
  input  logic  short_done,
  input  logic  long_done,
  output logic  restart,
  output lamp_t hwy,
  output lamp_t farm
);

  phase_e state_q;
  phase_e state_d;

  // Next-phase function
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_HWY_GO:    if (car && long_done)   state_d = PH_HWY_WARN;
      PH_HWY_WARN:  if (short_done)         state_d = PH_FARM_GO;
      PH_FARM_GO:   if (!car || long_done)  state_d = PH_FARM_WARN;
      PH_FARM_WARN: if (short_done)         state_d = PH_HWY_GO;
      default:                              state_d = PH_HWY_GO;
    endcase
  end

  // Timer restart on every phase change; also the register enable
  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_HWY_GO;
    end else if (restart) begin
      state_q <= state_d;
    end
  end

  // Lamp decode
  always_comb begin
    hwy  = '{go: 1'b0, warn: 1'b0, stop: 1'b1};
    farm = '{go: 1'b0, warn: 1'b0, stop: 1'b1};
    unique case (state_q)
      PH_HWY_GO:    hwy  = '{go: 1'b1, warn: 1'b0, stop: 1'b0};
      PH_HWY_WARN:  hwy  = '{go: 1'b0, warn: 1'b1, stop: 1'b0};
      PH_FARM_GO:   farm = '{go: 1'b1, warn: 1'b0, stop: 1'b0};
      PH_FARM_WARN: farm = '{go: 1'b0, warn: 1'b1, stop: 1'b0};
      default:      hwy  = '{go: 1'b1, warn: 1'b0, stop: 1'b0};
    endcase
  end

  // R1: at least one road shows red in every cycle
  assert_no_conflict_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hwy.stop || farm.stop);

  // R3: highway green holds until car and long expiry coincide
  assert_hwy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HWY_GO && !(car && long_done)) |=> state_q == PH_HWY_GO);

  // R4: highway yellow leaves for farm green on short expiry
  assert_hwy_warn_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HWY_WARN && short_done) |=> state_q == PH_FARM_GO);

  // R5 and R6: farm green ends on no car or long expiry
  assert_farm_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_FARM_GO && (!car || long_done)) |=> state_q == PH_FARM_WARN);

  // R7: farm yellow returns to highway green on short expiry
  assert_farm_warn_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_FARM_WARN && short_done) |=> state_q == PH_HWY_GO);

endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl #(
  parameter int SHORT_CYC   = 4,
  parameter int LONG_CYC    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic car_i,
  output logic hwy_grn_o,
  output logic hwy_yel_o,
  output logic hwy_red_o,
  output logic farm_grn_o,
  output logic farm_yel_o,
  output logic farm_red_o
);

  import xing_pkg::*;

  logic  rst_n_int;
  logic  car_s;
  logic  restart;
  logic  short_done;
  logic  long_done;
  lamp_t hwy_l;
  lamp_t farm_l;

  // Reset: asynchronous assert, synchronised release
  xing_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk_i),
    .rst_n(rst_ni),
    .din  (1'b1),
    .dout (rst_n_int)
  );

  xing_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_car_sync (
    .clk  (clk_i),
    .rst_n(rst_n_int),
    .din  (car_i),
    .dout (car_s)
  );

  xing_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk       (clk_i),
    .rst_n     (rst_n_int),
    .restart   (restart),
    .short_done(short_done),
    .long_done (long_done)
  );

  xing_fsm u_fsm (
    .clk       (clk_i),
    .rst_n     (rst_n_int),
    .car       (car_s),
    .short_done(short_done),
    .long_done (long_done),
    .restart   (restart),
    .hwy       (hwy_l),
    .farm      (farm_l)
  );

  assign hwy_grn_o  = hwy_l.go;
  assign hwy_yel_o  = hwy_l.warn;
  assign hwy_red_o  = hwy_l.stop;
  assign farm_grn_o = farm_l.go;
  assign farm_yel_o = farm_l.warn;
  assign farm_red_o = farm_l.stop;

endmodule

// File: tb/tb_xing_light_ctrl.sv
`timescale 1ns/1ps
module tb_xing_light_ctrl;

  localparam int SHORT = 4;
  localparam int LONG  = 12;
  localparam int HG = 0, HY = 1, FG = 2, FY = 3, BAD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0;
  logic hg, hy, hr, fg, fy, fr;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  xing_light_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .car_i(car),
    .hwy_grn_o(hg), .hwy_yel_o(hy), .hwy_red_o(hr),
    .farm_grn_o(fg), .farm_yel_o(fy), .farm_red_o(fr)
  );

  function automatic int phase();
    if (hg && !hy && !hr && fr && !fg && !fy) return HG;
    if (hy && !hg && !hr && fr && !fg && !fy) return HY;
    if (fg && !fy && !fr && hr && !hg && !hy) return FG;
    if (fy && !fg && !fr && hr && !hg && !hy) return FY;
    return BAD;
  endfunction

  task automatic expect_int(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Count consecutive falling-edge samples of one phase; ends on the first other one.
  task automatic span(input int ph, output int len);
    len = 0;
    while (phase() == ph && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  // R1: lamp legality checked on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      n_cmp++;
      if (($countones({hg, hy, hr}) != 1) || ($countones({fg, fy, fr}) != 1) ||
          (!hr && !fr)) begin
        n_bad++;
        $display("FAIL R1: actual hwy=%b%b%b farm=%b%b%b expected one lamp per road and one red",
                 hg, hy, hr, fg, fy, fr);
      end
    end
  end

  task automatic t_reset_state();
    int len;
    car = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_int("R2 reset phase", phase(), HG);
    rst_n = 1'b1;
    span(HG, len);
    expect_int("R2 first highway green after release", len, LONG + 3);
  endtask

  task automatic t_full_cycle_car_held();
    int len;
    span(HY, len);
    expect_int("R4 highway yellow length", len, SHORT + 1);
    span(FG, len);
    expect_int("R6 farm green cap", len, LONG + 1);
    span(FY, len);
    expect_int("R7 farm yellow length", len, SHORT + 1);
    span(HG, len);
    expect_int("R3 highway minimum green", len, LONG + 1);
    span(HY, len);
    expect_int("R4 highway yellow length again", len, SHORT + 1);
  endtask

  task automatic t_farm_early_end();
    int len;
    expect_int("R5 entered farm green", phase(), FG);
    repeat (2) @(negedge clk);
    car = 1'b0;
    span(FG, len);
    expect_int("R5 farm green after car leaves", len + 2, 5);
    span(FY, len);
    expect_int("R7 farm yellow after early end", len, SHORT + 1);
  endtask

  task automatic t_no_car_holds();
    int held = 0;
    for (int i = 0; i < 3 * LONG; i++) begin
      if (phase() == HG) held++;
      @(negedge clk);
    end
    expect_int("R3 highway green held without car", held, 3 * LONG);
  endtask

  task automatic t_sync_latency();
    int len;
    car = 1'b1;
    span(HG, len);
    expect_int("R8 sensor latency to highway yellow", len, 3);
    expect_int("R8 yellow follows", phase(), HY);
    span(HY, len);
    expect_int("R9 timer restarted for yellow", len, SHORT + 1);
  endtask

  task automatic t_reset_mid_run();
    expect_int("R2 at farm green before reset", phase(), FG);
    #1 rst_n = 1'b0;
    #1 expect_int("R2 async reset to highway green", phase(), HG);
    @(negedge clk);
    expect_int("R2 held in reset", phase(), HG);
    car = 1'b0;
    rst_n = 1'b1;
    repeat (2 * LONG) @(negedge clk);
    expect_int("R2 idle after reset without car", phase(), HG);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_full_cycle_car_held();
    t_farm_early_end();
    t_no_car_holds();
    t_sync_latency();
    t_reset_mid_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule